// File: doc/BRIEF.md
# Framebuffer Scanout Display Controller

This block drives a fixed 640x480 true-color panel or VGA output from an image held in memory. It runs the raster timing counters, issues one memory read per visible pixel, splits each returned 32-bit word into 8-bit red, green and blue, and delays the sync and data-enable signals so they line up with the returned pixels. A two-register write port sets the image base address and a control word.

The image is stored one pixel per word, with a row pitch of 1024 words, of which only the first 640 are ever read. The base address keeps only its top 11 bits, so the image always starts on a 2 MiB boundary. Setting the rotate bit reverses the whole read order, which turns the picture by 180 degrees. New register values are copied into the working set only when vertical sync begins, so no frame mixes two settings. Memory is a request port answered with a fixed latency.

Top module: `fb_scanout`

## Requirements
- R1: While rst_ni is low, hsync_no and vsync_no are high, de_o is low, red_o/green_o/blue_o are zero and mem_req_o is low.
- R2: hsync_no is low for H_SYNC cycles once every H_ACT+H_FP+H_SYNC+H_BP cycles, and goes low H_FP cycles after de_o falls. vsync_no is low for V_SYNC whole lines. Both syncs run whether or not the display is enabled.
- R3: With rotation off, the pixel in visible row r and column c is read from byte address base + 4*(r*ROW_STRIDE + c), in raster order.
- R4: Only columns 0 to H_ACT-1 of each row are read. An enabled frame issues exactly H_ACT*V_ACT requests.
- R5: Only base bits 31:21 are used. Bits 20:0 of the written value are taken as zero.
- R6: With rotation on (control bit 1), the k-th request of a frame reads the address that the last-minus-k pixel would have in normal order. The first request is row V_ACT-1, column H_ACT-1, and the address falls along each row and moves up row by row.
- R7: A word returned MEM_LAT cycles after its request shows one cycle later with red = bits 23:16, green = bits 15:8 and blue = bits 7:0. Bits 31:24 are ignored.
- R8: With control bit 0 clear, no requests are issued and de_o stays low. Whenever de_o is low, all color outputs are zero.
- R9: A write with reg_addr_i=0 sets the base and a write with reg_addr_i=1 sets the control word. Either takes effect only at the next start of vertical sync, and the frame in progress keeps its old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 base, 1 control |
| reg_wdata_i | input | AW | Register write data |
| mem_req_o | output | 1 | Pixel read request |
| mem_addr_o | output | AW | Byte address of requested pixel |
| mem_rdata_i | input | 32 | Pixel word, valid MEM_LAT cycles after request |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Pixel data valid |
| red_o | output | 8 | Red level |
| green_o | output | 8 | Green level |
| blue_o | output | 8 | Blue level |

## Verification
The bench shrinks the raster to 8x6 visible pixels with short porches and a 16-word row pitch, and uses a read latency of 3. A frame then lasts 176 cycles, so two dozen frames fit in a short run. Each request address is compared with the address the requirements give for both scan orders. Request counts per frame, sync widths and the de-to-sync spacing are measured. Because the row pitch is twice the visible width, a stray read of a hidden column would show up directly in the address checks.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef struct packed {
    logic rot;
    logic en;
  } fbs_ctrl_t;

  localparam int unsigned FBS_WORD_BYTES = 4;
endpackage

// File: rtl/fbs_regs.sv
module fbs_regs
  import fbs_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned BASE_LSB = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          addr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          frame_tick_i,
  output logic [AW-1:0] base_o,
  output fbs_ctrl_t     ctrl_o
);
  localparam logic [AW-1:0] BASE_MASK = ~((AW'(1) << BASE_LSB) - AW'(1));

  logic [AW-1:0] base_stg_q;
  fbs_ctrl_t     ctrl_stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_stg_q <= '0;
      ctrl_stg_q <= '0;
    end else if (we_i) begin
      if (addr_i) ctrl_stg_q <= fbs_ctrl_t'(wdata_i[1:0]);
      else        base_stg_q <= wdata_i & BASE_MASK;
    end
  end

  // working set swaps only at vsync start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      ctrl_o <= '0;
    end else if (frame_tick_i) begin
      base_o <= base_stg_q;
      ctrl_o <= ctrl_stg_q;
    end
  end

  a_r9_hold_mid_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_tick_i |=> ($stable(base_o) && $stable(ctrl_o)));
endmodule

// File: rtl/fbs_timing.sv
module fbs_timing #(
  parameter int unsigned H_ACT  = 640,
  parameter int unsigned H_FP   = 16,
  parameter int unsigned H_SYNC = 96,
  parameter int unsigned H_BP   = 48,
  parameter int unsigned V_ACT  = 480,
  parameter int unsigned V_FP   = 10,
  parameter int unsigned V_SYNC = 2,
  parameter int unsigned V_BP   = 33,
  localparam int unsigned H_TOT = H_ACT + H_FP + H_SYNC + H_BP,
  localparam int unsigned V_TOT = V_ACT + V_FP + V_SYNC + V_BP,
  localparam int unsigned HW    = $clog2(H_TOT),
  localparam int unsigned VW    = $clog2(V_TOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o,
  output logic          active_o,
  output logic          hs_n_o,
  output logic          vs_n_o,
  output logic          frame_tick_o
);
  localparam int unsigned HS_BEG = H_ACT + H_FP;
  localparam int unsigned VS_BEG = V_ACT + V_FP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_o <= '0;
      vcnt_o <= '0;
    end else if (hcnt_o == HW'(H_TOT - 1)) begin
      hcnt_o <= '0;
      vcnt_o <= (vcnt_o == VW'(V_TOT - 1)) ? '0 : vcnt_o + VW'(1);
    end else begin
      hcnt_o <= hcnt_o + HW'(1);
    end
  end

  always_comb begin
    active_o     = (hcnt_o < HW'(H_ACT)) && (vcnt_o < VW'(V_ACT));
    hs_n_o       = !((hcnt_o >= HW'(HS_BEG)) && (hcnt_o < HW'(HS_BEG + H_SYNC)));
    vs_n_o       = !((vcnt_o >= VW'(VS_BEG)) && (vcnt_o < VW'(VS_BEG + V_SYNC)));
    frame_tick_o = (hcnt_o == '0) && (vcnt_o == VW'(VS_BEG));
  end

  a_r2_vs_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_n_o |-> !active_o);
  a_r2_hs_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_n_o |-> !active_o);
endmodule

// File: rtl/fbs_fetch.sv
module fbs_fetch
  import fbs_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned H_ACT      = 640,
  parameter int unsigned V_ACT      = 480,
  parameter int unsigned ROW_STRIDE = 1024,
  parameter int unsigned HW         = 10,
  parameter int unsigned VW         = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] hcnt_i,
  input  logic [VW-1:0] vcnt_i,
  input  logic          active_i,
  input  logic [AW-1:0] base_i,
  input  fbs_ctrl_t     ctrl_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] row_w, col_w, word_w;

  always_comb begin
    if (ctrl_i.rot) begin
      row_w = AW'(V_ACT - 1) - AW'(vcnt_i);
      col_w = AW'(H_ACT - 1) - AW'(hcnt_i);
    end else begin
      row_w = AW'(vcnt_i);
      col_w = AW'(hcnt_i);
    end
    word_w = row_w * AW'(ROW_STRIDE) + col_w;
    addr_o = base_i + (word_w << $clog2(FBS_WORD_BYTES));
    req_o  = active_i && ctrl_i.en;
  end

  logic [AW-1:0] chk_off;
  assign chk_off = (addr_o - base_i) >> $clog2(FBS_WORD_BYTES);

  a_r4_col_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ((chk_off % AW'(ROW_STRIDE)) < AW'(H_ACT)));
  a_r3_first_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ctrl_i.rot && hcnt_i == '0 && vcnt_i == '0) |-> addr_o == base_i);
  a_r6_first_rot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ctrl_i.rot && hcnt_i == '0 && vcnt_i == '0) |->
      addr_o == base_i + AW'(((V_ACT - 1) * ROW_STRIDE + H_ACT - 1) * FBS_WORD_BYTES));
endmodule

// File: rtl/fbs_pixout.sv
module fbs_pixout #(
  parameter int unsigned MEM_LAT = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        de_i,
  input  logic        hs_n_i,
  input  logic        vs_n_i,
  input  logic [31:0] rdata_i,
  output logic        de_o,
  output logic        hs_n_o,
  output logic        vs_n_o,
  output logic [7:0]  red_o,
  output logic [7:0]  green_o,
  output logic [7:0]  blue_o
);
  localparam logic [2:0] IDLE = 3'b011; // {de, hs_n, vs_n}

  logic [2:0] stg_q [MEM_LAT];
  logic       unused_alpha;
  assign unused_alpha = ^rdata_i[31:24];

  for (genvar g = 0; g < MEM_LAT; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[g] <= IDLE;
      else if (g == 0) stg_q[g] <= {de_i, hs_n_i, vs_n_i};
      else             stg_q[g] <= stg_q[(g == 0) ? 0 : g - 1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {de_o, hs_n_o, vs_n_o} <= IDLE;
      {red_o, green_o, blue_o} <= '0;
    end else begin
      {de_o, hs_n_o, vs_n_o} <= stg_q[MEM_LAT-1];
      {red_o, green_o, blue_o} <= stg_q[MEM_LAT-1][2] ? rdata_i[23:0] : 24'h0;
    end
  end

  a_r8_blank_black: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> ({red_o, green_o, blue_o} == 24'h0));
endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
  import fbs_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned BASE_LSB   = 21,
  parameter int unsigned H_ACT      = 640,
  parameter int unsigned H_FP       = 16,
  parameter int unsigned H_SYNC     = 96,
  parameter int unsigned H_BP       = 48,
  parameter int unsigned V_ACT      = 480,
  parameter int unsigned V_FP       = 10,
  parameter int unsigned V_SYNC     = 2,
  parameter int unsigned V_BP       = 33,
  parameter int unsigned ROW_STRIDE = 1024,
  parameter int unsigned MEM_LAT    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_addr_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          hsync_no,
  output logic          vsync_no,
  output logic          de_o,
  output logic [7:0]    red_o,
  output logic [7:0]    green_o,
  output logic [7:0]    blue_o
);
  localparam int unsigned HW = $clog2(H_ACT + H_FP + H_SYNC + H_BP);
  localparam int unsigned VW = $clog2(V_ACT + V_FP + V_SYNC + V_BP);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          active, hs_n, vs_n, frame_tick;
  logic [AW-1:0] base;
  fbs_ctrl_t     ctrl;

  fbs_regs #(.AW(AW), .BASE_LSB(BASE_LSB)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .frame_tick_i(frame_tick), .base_o(base), .ctrl_o(ctrl)
  );

  fbs_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk_i, .rst_ni,
    .hcnt_o(hcnt), .vcnt_o(vcnt), .active_o(active),
    .hs_n_o(hs_n), .vs_n_o(vs_n), .frame_tick_o(frame_tick)
  );

  fbs_fetch #(
    .AW(AW), .H_ACT(H_ACT), .V_ACT(V_ACT), .ROW_STRIDE(ROW_STRIDE), .HW(HW), .VW(VW)
  ) u_fetch (
    .clk_i, .rst_ni,
    .hcnt_i(hcnt), .vcnt_i(vcnt), .active_i(active),
    .base_i(base), .ctrl_i(ctrl),
    .req_o(mem_req_o), .addr_o(mem_addr_o)
  );

  fbs_pixout #(.MEM_LAT(MEM_LAT)) u_pixout (
    .clk_i, .rst_ni,
    .de_i(active && ctrl.en), .hs_n_i(hs_n), .vs_n_i(vs_n), .rdata_i(mem_rdata_i),
    .de_o, .hs_n_o(hsync_no), .vs_n_o(vsync_no),
    .red_o, .green_o, .blue_o
  );

  a_r8_no_fetch_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en |-> !mem_req_o);
endmodule

// File: tb/fb_scanout_tb.sv
module fb_scanout_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, H_ACT = 8, H_FP = 2, H_SYNC = 3, H_BP = 3;
  localparam int V_ACT = 6, V_FP = 1, V_SYNC = 2, V_BP = 2;
  localparam int STRIDE = 16, LAT = 3;
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam logic [31:0] MASK = 32'hFFE0_0000;

  logic clk_i = 0, rst_ni = 0;
  logic reg_we_i = 0, reg_addr_i = 0;
  logic [AW-1:0] reg_wdata_i = '0;
  logic mem_req_o, hsync_no, vsync_no, de_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_rdata_i;
  logic [7:0] red_o, green_o, blue_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fb_scanout #(
    .AW(AW), .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .ROW_STRIDE(STRIDE), .MEM_LAT(LAT)
  ) dut_i (.*);

  int nvec = 0, nbad = 0, frames = 0;
  logic [31:0] salt = 32'h1234_5678;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ salt;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic rot, input int k);
    int r, c;
    r = k / H_ACT; c = k % H_ACT;
    if (rot) begin r = V_ACT - 1 - r; c = H_ACT - 1 - c; end
    return (b & MASK) + 32'(4 * (r * STRIDE + c));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // fixed-latency memory
  logic [31:0] mpipe [LAT];
  always @(posedge clk_i) begin
    mpipe[0] <= mem_word(mem_addr_o);
    for (int i = 1; i < LAT; i++) mpipe[i] <= mpipe[i-1];
  end
  assign mem_rdata_i = mpipe[LAT-1];

  // bench frame model
  logic [31:0] stg_base = 0, cur_base = 0;
  logic stg_en = 0, stg_rot = 0, cur_en = 0, cur_rot = 0;
  int req_cnt = 0;
  logic [31:0] q [64];
  int qw = 0, qr = 0;
  logic hs_p = 1, vs_p = 1, de_p = 0;
  int hs_low = 0, vs_low = 0, hs_per = 0, gap = -1;
  bit hs_seen = 0;

  always @(negedge clk_i) if (rst_ni) begin
    if (mem_req_o) begin
      logic [31:0] e;
      e = exp_addr(cur_base, cur_rot, req_cnt);
      chk(cur_en, "R8 request while disabled", 32'(mem_req_o), 0);
      chk(req_cnt < H_ACT * V_ACT, "R4 request count in frame", 32'(req_cnt), H_ACT * V_ACT);
      chk(mem_addr_o == e, cur_rot ? "R6 rotated address" : "R3/R5 address", mem_addr_o, e);
      q[qw % 64] = mem_word(mem_addr_o); qw++;
      req_cnt++;
    end
    if (de_o) begin
      chk(qr < qw, "R7 pixel without request", 32'(qr), 32'(qw));
      chk({red_o, green_o, blue_o} == q[qr % 64][23:0], "R7 unpacked pixel",
          {8'h0, red_o, green_o, blue_o}, {8'h0, q[qr % 64][23:0]});
      qr++;
    end else begin
      chk({red_o, green_o, blue_o} == 24'h0, "R8 blank is black", {8'h0, red_o, green_o, blue_o}, 0);
    end
    // R2 horizontal sync
    if (!hsync_no) hs_low++;
    if (hsync_no && !hs_p) begin
      chk(hs_low == H_SYNC, "R2 hsync width", 32'(hs_low), H_SYNC);
      hs_low = 0;
    end
    if (gap >= 0) gap++;
    if (!de_o && de_p) gap = 0;
    if (!hsync_no && hs_p) begin
      if (hs_seen) chk(hs_per == H_TOT, "R2 line period", 32'(hs_per), H_TOT);
      if (gap >= 0) chk(gap == H_FP, "R2 de fall to hsync", 32'(gap), H_FP);
      hs_seen = 1; hs_per = 0; gap = -1;
    end
    hs_per++;
    // R2 vertical sync, frame boundary for R4/R9
    if (!vsync_no) vs_low++;
    if (vsync_no && !vs_p) begin
      chk(vs_low == V_SYNC * H_TOT, "R2 vsync width", 32'(vs_low), V_SYNC * H_TOT);
      vs_low = 0;
    end
    if (!vsync_no && vs_p) begin
      chk(req_cnt == (cur_en ? H_ACT * V_ACT : 0), "R4/R9 requests per frame",
          32'(req_cnt), cur_en ? H_ACT * V_ACT : 0);
      cur_base = stg_base; cur_en = stg_en; cur_rot = stg_rot;
      req_cnt = 0; frames++;
    end
    hs_p = hsync_no; vs_p = vsync_no; de_p = de_o;
  end

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk_i); #1;
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    if (a) begin stg_en = d[0]; stg_rot = d[1]; end
    else   stg_base = d & MASK;
    @(negedge clk_i); #1;
    reg_we_i = 0;
  endtask

  task automatic wait_frames(input int n);
    int t;
    t = frames + n;
    while (frames < t) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    salt = $urandom;
    repeat (3) begin
      @(negedge clk_i);
      chk(hsync_no && vsync_no && !de_o && !mem_req_o && {red_o, green_o, blue_o} == 0,
          "R1 reset state", {hsync_no, vsync_no, de_o, mem_req_o, red_o, green_o, blue_o}, 32'h0C00_0000);
    end
    #1 rst_ni = 1;
    wait_frames(1);
    // R3 R5: base with low bits set, normal order
    wr(0, 32'h1234_5678); wr(1, 32'h1);
    wait_frames(2);
    // R6: rotation at top of address space
    wr(0, 32'hFFFF_FFFF); wr(1, 32'h3);
    wait_frames(2);
    // R8: disabled, rotate bit alone
    wr(1, 32'h2);
    wait_frames(2);
    // R9: change mid-frame, current frame keeps its settings
    wr(0, 32'h4000_0000); wr(1, 32'h1);
    wait_frames(1);
    repeat (3 * H_TOT) @(negedge clk_i);
    wr(0, 32'h8020_0000); wr(1, 32'h0);
    wait_frames(2);
    wr(1, 32'h3);
    repeat (2 * H_TOT) @(negedge clk_i);
    wr(0, 32'h0060_0000);
    wait_frames(2);
    // random mix
    for (int i = 0; i < 10; i++) begin
      wr(0, $urandom);
      wr(1, $urandom & 32'h3);
      wait_frames(2);
    end
    chk(qr == qw, "R7 all fetched pixels shown", 32'(qr), 32'(qw));
    finish_run();
  end
endmodule